// File: doc/BRIEF.md
# Three-Axis Sample FIFO with Watermark and Event Timer

This block holds angular-rate samples between the point where a sensor front end produces them and the point where a readout path collects them. Each entry is one sample of three axes packed into a single word. A producer strobes samples in, and a consumer pops them from the head. A 2-bit mode selects whether the buffer is off, runs as a ring that keeps the newest samples, or stops accepting samples once it is full.

Two bytes report status. The status byte carries the stored count, a watermark flag and an overflow flag. The event byte carries an event flag and a small timer. The event flag is the OR of the watermark and overflow flags. The timer counts output-data-rate ticks from the moment the event flag came up, so the consumer can tell how stale the oldest unread event is.

All outputs are registered. Each output changes on the clock edge that samples the input causing the change.

Top module: `sensor_sample_fifo`

## Requirements
- R1: After reset, and at every later cycle, status bits 5:0 hold the number of stored samples (0 to 32). An accepted push adds one, an accepted pop removes one, and a push together with a pop leaves the count unchanged.
- R2: The head output presents the oldest stored sample whenever the count is nonzero. Samples leave in the order they arrived.
- R3: Mode 1 is circular. A push into a full buffer discards the oldest sample, stores the new one, and keeps the count at 32.
- R4: Modes 2 and 3 stop on full. A push into a full buffer is dropped, so both the head and the count are left unchanged.
- R5: Mode 0 turns the buffer off. Pushes are ignored, and the next cycle shows a count of 0 and a clear overflow flag.
- R6: Status bit 6, the watermark flag, is 1 exactly when the watermark input is nonzero and the count is at least the watermark. A watermark of 0 keeps the flag at 0.
- R7: Status bit 7, the overflow flag, is set by a push that arrives while the count is 32 and the mode is nonzero.
- R8: Once set, the overflow flag stays set until the count falls below 32 or the mode input takes a different value.
- R9: Event byte bit 5 equals status bit 6 OR status bit 7. Event byte bits 7:6 are always 0.
- R10: Event byte bits 4:0 are 0 while the event flag is 0, and they are also 0 in the cycle the flag rises. Each later data-rate tick with the flag still high adds one, and the count saturates at 31.
- R11: A pop request while the buffer is empty has no effect on the count, the flags or the pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Push strobe for a new sample |
| smp_data | input | 48 | Sample word: three 16-bit axis values |
| pop_req | input | 1 | Pop strobe that removes the head sample |
| odr_tick | input | 1 | One-cycle pulse per output-data-rate period |
| fifo_mode | input | 2 | 0 off, 1 circular, 2 or 3 stop on full |
| wm_level | input | 6 | Watermark count; 0 turns the watermark flag off |
| head_data | output | 48 | Oldest stored sample |
| status_byte | output | 8 | Bit 7 overflow, bit 6 watermark, bits 5:0 count |
| event_byte | output | 8 | Bit 5 event flag, bits 4:0 elapsed ticks |

## Verification
The bench targets the boundary at a count of 32. Pushes arrive there in circular mode, where a design that does not advance the read side returns stale heads. Pushes also arrive there in stop mode, where a design that still stores the sample corrupts the head. A push and a pop in the same cycle on a full buffer are covered, and so is a mode switch while overflow is set; a design that misses the mode comparison keeps the overflow flag stuck. The timer is held high for more than 31 ticks to expose wraparound. A watermark of 0 is applied to expose an always-true flag, and pops on an empty buffer are applied to expose count underflow.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Operating-mode encoding on the 2-bit mode input.
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_RING = 2'd1;

  // Field widths of the two report bytes.
  localparam int STAT_CNT_W = 6;
  localparam int EVT_TMR_W  = 5;

  // Map a count onto the 6-bit count field of the status byte.
  function automatic logic [STAT_CNT_W-1:0] cnt_field(input logic [7:0] c);
    return c[STAT_CNT_W-1:0];
  endfunction
endpackage

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [1:0]       mode,
  output logic [PTR_W-1:0] wr_ptr_q,
  output logic [PTR_W-1:0] rd_ptr_next,
  output logic             wr_fire,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_next,
  output logic             arrive_full
);
  import sfifo_pkg::*;

  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_next;
  logic enabled, ring, full, empty, pop, push, drop_old, grow;

  always_comb begin
    enabled     = (mode != MODE_OFF);
    ring        = (mode == MODE_RING);
    full        = (count_q == CNT_W'(DEPTH));
    empty       = (count_q == '0);
    pop         = enabled && rd_req && !empty;
    push        = enabled && wr_req && (!full || ring);
    drop_old    = push && full && !pop;
    grow        = push && !drop_old;
    arrive_full = enabled && wr_req && full;
    wr_fire     = push;

    if (!enabled) begin
      count_next  = '0;
      rd_ptr_next = '0;
      wr_ptr_next = '0;
    end else begin
      count_next  = count_q + CNT_W'(grow) - CNT_W'(pop);
      rd_ptr_next = (pop || drop_old) ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
      wr_ptr_next = push ? wr_ptr_q + PTR_W'(1) : wr_ptr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      count_q  <= count_next;
      rd_ptr_q <= rd_ptr_next;
      wr_ptr_q <= wr_ptr_next;
    end
  end

  // R1: the count never leaves its legal range
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R3: a circular push into a full buffer keeps it full and moves the read side
  p_ring_full_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RING && count_q == CNT_W'(DEPTH) && wr_req && !rd_req)
    |=> (count_q == CNT_W'(DEPTH)) && !$stable(rd_ptr_q));

  // R4: a stop-mode push into a full buffer changes nothing
  p_stop_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && count_q == CNT_W'(DEPTH) && wr_req && !rd_req)
    |=> (count_q == CNT_W'(DEPTH)) && $stable(rd_ptr_q) && $stable(wr_ptr_q));

  // R5: mode 0 empties the buffer
  p_off_flush_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (count_q == '0));

  // R11: a pop on an empty buffer without a push leaves it empty
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && !wr_req) |=> (count_q == '0) && $stable(rd_ptr_q));
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 48,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr_next,
  output logic [DATA_W-1:0] head_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: no reset, so the array can map onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read at the next head address, with write-first forwarding.
  always_ff @(posedge clk) begin
    if (rst)                              head_q <= '0;
    else if (we && (waddr == raddr_next)) head_q <= wdata;
    else                                  head_q <= mem[raddr_next];
  end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int CNT_W = 6,
  parameter int FULL  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [5:0]       wmark,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] count_next,
  input  logic             arrive_full,
  output logic             ovf_q,
  output logic             wmf_q,
  output logic             evt_next
);
  localparam int CMP_W = (CNT_W > 6 ? CNT_W : 6) + 1;

  logic [1:0] mode_q;
  logic mode_chg, ovf_next, wmf_next;

  always_comb begin
    mode_chg = (mode != mode_q);
    if (mode_chg || mode == 2'd0 || count_next != CNT_W'(FULL))
      ovf_next = 1'b0;
    else
      ovf_next = ovf_q || arrive_full;
    wmf_next = (wmark != '0) && (CMP_W'(count_next) >= CMP_W'(wmark));
    evt_next = ovf_next || wmf_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ovf_q  <= 1'b0;
      wmf_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      ovf_q  <= ovf_next;
      wmf_q  <= wmf_next;
    end
  end

  // R8: overflow is only ever reported with a full buffer
  p_ovf_full_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (count_q == CNT_W'(FULL)));

  // R7: a push arriving at full with the mode unchanged raises overflow
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
    (arrive_full && !mode_chg && count_next == CNT_W'(FULL)) |=> ovf_q);

  // R6: a zero watermark never raises the watermark flag
  p_wm_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (wmark == '0) |=> !wmf_q);
endmodule

// File: rtl/sfifo_evt_timer.sv
module sfifo_evt_timer #(
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             odr_tick,
  input  logic             evt_next,
  output logic             evt_q,
  output logic [TMR_W-1:0] tmr_q
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      evt_q <= evt_next;
      if (!evt_next || !evt_q)             tmr_q <= '0;
      else if (odr_tick && tmr_q != TMR_MAX) tmr_q <= tmr_q + TMR_W'(1);
    end
  end

  // R10: the timer reads zero whenever no event is pending
  p_tmr_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !evt_q |-> (tmr_q == '0));

  // R10: a tick during a held event leaves a nonzero count
  p_tmr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (evt_q && evt_next && odr_tick) |=> (tmr_q != '0));

  // R10: a saturated timer stays saturated while the event persists
  p_tmr_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (evt_q && evt_next && tmr_q == TMR_MAX) |=> (tmr_q == TMR_MAX));
endmodule

// File: rtl/sensor_sample_fifo.sv
module sensor_sample_fifo #(
  parameter int DATA_W = 48,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              pop_req,
  input  logic              odr_tick,
  input  logic [1:0]        fifo_mode,
  input  logic [5:0]        wm_level,
  output logic [DATA_W-1:0] head_data,
  output logic [7:0]        status_byte,
  output logic [7:0]        event_byte
);
  import sfifo_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr_next;
  logic [CNT_W-1:0] count_q, count_next;
  logic wr_fire, arrive_full, ovf_q, wmf_q, evt_next, evt_q;
  logic [EVT_TMR_W-1:0] tmr_q;

  sfifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .wr_req(smp_valid), .rd_req(pop_req), .mode(fifo_mode),
    .wr_ptr_q(wr_ptr), .rd_ptr_next(rd_ptr_next), .wr_fire(wr_fire),
    .count_q(count_q), .count_next(count_next), .arrive_full(arrive_full)
  );

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(wr_fire), .waddr(wr_ptr), .wdata(smp_data),
    .raddr_next(rd_ptr_next), .head_q(head_data)
  );

  sfifo_flags #(.CNT_W(CNT_W), .FULL(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .mode(fifo_mode), .wmark(wm_level),
    .count_q(count_q), .count_next(count_next), .arrive_full(arrive_full),
    .ovf_q(ovf_q), .wmf_q(wmf_q), .evt_next(evt_next)
  );

  sfifo_evt_timer #(.TMR_W(EVT_TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .odr_tick(odr_tick), .evt_next(evt_next),
    .evt_q(evt_q), .tmr_q(tmr_q)
  );

  assign status_byte = {ovf_q, wmf_q, cnt_field(8'(count_q))};
  assign event_byte  = {2'b00, evt_q, tmr_q};

  // R9: the event flag tracks the OR of the two status flags
  p_evt_or_r9: assert property (@(posedge clk) disable iff (rst)
    event_byte[5] == (status_byte[7] || status_byte[6]));
endmodule

// File: tb/sensor_sample_fifo_tb_top.sv
module sensor_sample_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic pop_req = 1'b0;
  logic odr_tick = 1'b0;
  logic [1:0] fifo_mode = 2'd0;
  logic [5:0] wm_level = 6'd0;
  logic [DW-1:0] head_data;
  logic [7:0] status_byte, event_byte;

  int checks = 0;
  int errors = 0;
  string ph = "R1";

  // Reference model state
  logic [DW-1:0] mq[$];
  bit m_ovf = 0, m_wmf = 0, m_evt = 0;
  int m_tmr = 0;
  logic [1:0] m_mode_prev = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_sample_fifo #(.DATA_W(DW), .DEPTH(32)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .pop_req(pop_req), .odr_tick(odr_tick), .fifo_mode(fifo_mode),
    .wm_level(wm_level), .head_data(head_data),
    .status_byte(status_byte), .event_byte(event_byte)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit wm_flag(input int n, input logic [5:0] w);
    return (w != 0) && (n >= int'(w));
  endfunction

  // Advance the model by one clock edge using the inputs present at that edge.
  task automatic model_step();
    int n0 = mq.size();
    bit en = (fifo_mode != 2'd0);
    bit ring = (fifo_mode == 2'd1);
    bit full0 = (n0 == 32);
    bit pop = en && pop_req && (n0 > 0);
    bit arrive = en && smp_valid && full0;
    bit new_evt;
    if (!en) mq.delete();
    else begin
      if (pop) void'(mq.pop_front());
      if (smp_valid && (!full0 || ring)) begin
        if (full0 && !pop) void'(mq.pop_front());
        mq.push_back(smp_data);
      end
    end
    if (fifo_mode != m_mode_prev || !en || mq.size() != 32) m_ovf = 0;
    else m_ovf = m_ovf || arrive;
    m_wmf = wm_flag(mq.size(), wm_level);
    new_evt = m_ovf || m_wmf;
    if (!new_evt || !m_evt) m_tmr = 0;
    else if (odr_tick && m_tmr < 31) m_tmr++;
    m_evt = new_evt;
    m_mode_prev = fifo_mode;
  endtask

  task automatic compare();
    chk({ph, " count"}, 64'(status_byte[5:0]), 64'(mq.size()));
    chk("R6 watermark", 64'(status_byte[6]), 64'(m_wmf));
    chk({ph == "R8" ? "R8" : "R7", " overflow"}, 64'(status_byte[7]), 64'(m_ovf));
    chk("R9 event", 64'(event_byte[7:5]), 64'({2'b00, m_evt}));
    chk("R10 timer", 64'(event_byte[4:0]), 64'(m_tmr));
    if (mq.size() > 0) chk({ph == "R1" ? "R2" : ph, " head"}, 64'(head_data), 64'(mq[0]));
  endtask

  task automatic cyc(input bit wr, input bit rd, input bit tk);
    smp_valid = wr;
    pop_req = rd;
    odr_tick = tk;
    smp_data = {$urandom(), $urandom()};
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset status", 64'(status_byte), 64'h0);
    chk("R1 reset event", 64'(event_byte), 64'h0);

    // R2/R1: random traffic in circular mode
    ph = "R2";
    fifo_mode = 2'd1;
    wm_level = 6'd10;
    for (int i = 0; i < 400; i++)
      cyc(($urandom() % 10) < 6, ($urandom() % 10) < 4, (i % 3) == 0);

    // R3: fill past full in circular mode; R7 overflow rises
    ph = "R3";
    for (int i = 0; i < 45; i++) cyc(1'b1, 1'b0, (i % 2) == 0);
    cyc(1'b1, 1'b1, 1'b0);  // push and pop together at full

    // R8: mode switch to stop clears overflow
    ph = "R8";
    fifo_mode = 2'd2;
    cyc(1'b0, 1'b0, 1'b0);
    // R4: stop mode drops pushes at full; ticks drive timer to saturation (R10)
    ph = "R4";
    for (int i = 0; i < 45; i++) cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);  // push dropped, pop accepted
    fifo_mode = 2'd3;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0);
    // R8: a pop below 32 clears overflow
    ph = "R8";
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);

    // R6: watermark 0 turns the flag off
    ph = "R6";
    wm_level = 6'd0;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1);
    wm_level = 6'd27;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1);

    // R5: off mode flushes and ignores pushes
    ph = "R5";
    fifo_mode = 2'd0;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b1);

    // R11: pops on empty buffer
    ph = "R11";
    fifo_mode = 2'd2;
    wm_level = 6'd1;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);

    // mixed random in stop mode with a high watermark
    ph = "R4";
    wm_level = 6'd31;
    for (int i = 0; i < 300; i++)
      cyc(($urandom() % 10) < 7, ($urandom() % 10) < 2, ($urandom() % 4) == 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule